// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Register

This block collects the expiry events of a group of timer channels (five by default) and turns them into one level interrupt line per channel. A single 32-bit register holds both a per-channel enable field and a per-channel pending-status field. Every expiry pulse sets that channel's pending bit, whether or not the channel is enabled. The interrupt line for the channel goes high only when the channel is enabled in the cycle of the expiry.

Software writes the whole register in one access. The low field takes the new enable values directly. Each one written into the pending field clears that pending bit and drops the matching interrupt line. The counters that produce the expiry pulses, and any merging or ranking of the interrupt lines, sit outside this block.

Top module: `tmr_irq_status_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads as all zeros and every interrupt line is low.
- R2: An expiry pulse on channel x sets the pending bit at register bit 5+x, readable in the cycle after the pulse, whether or not channel x is enabled.
- R3: An expiry on channel x raises irq[x] in the following cycle only if enable bit x (register bit x) is set in the cycle of the expiry. The enable value held before any write in that same cycle is the one that counts.
- R4: A write loads register bits [4:0] into the enables, readable in the cycle after the write.
- R5: Writing one to register bit 5+x clears pending bit x and lowers irq[x] in the cycle after. Writing zero to a pending bit leaves it unchanged.
- R6: Setting an enable bit while its pending bit is already set does not raise irq for that channel. Only a later expiry does.
- R7: Clearing an enable bit does not lower an interrupt line that is already high.
- R8: When an expiry and a write-one-to-clear hit the same pending bit in one cycle, the pending bit stays set, and irq follows R3.
- R9: Register bits [31:10] always read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| expire | input | 5 | One-cycle expiry pulse per channel |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: [4:0] enables, [9:5] write-one-to-clear pending |
| rd_data | output | 32 | Register contents: [4:0] enables, [9:5] pending, rest zero |
| irq | output | 5 | Level interrupt line per channel |

## Verification
The hardest case to reach is the collision cycle. In that cycle an expiry, a write-one-to-clear of the same pending bit, and a change of that channel's enable all land on one clock edge, and the result depends on which enable value counts. The stimulus drives the expiry and the write in the same low clock phase. It checks the case once with the old enable set and once with the new enable only, so that the pending bit stays set in both cases while the interrupt line rises in only one. The bench also drives sequences that leave a pending bit set while enables change: the line must neither rise nor fall until an expiry or a clear arrives.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned DEF_NUM_CH = 5;
  localparam int unsigned DEF_REG_W  = 32;

  // Pending field starts just above the enable field.
  function automatic int unsigned pend_lsb(input int unsigned num_ch);
    return num_ch;
  endfunction

  function automatic int unsigned used_width(input int unsigned num_ch);
    return 2 * num_ch;
  endfunction
endpackage

// File: rtl/tmr_irq_rst_sync.sv
module tmr_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_en_bits,
  output logic [NUM_CH-1:0] enable
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_d;
  logic              en_ce;

  always_comb begin
    en_ce = wr_en;
    en_d  = wr_en_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign enable = en_q;
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic enable,
  input  logic clr_req,
  output logic pending,
  output logic irq
);
  logic pend_q, pend_d;
  logic irq_q, irq_d;
  logic ch_ce;

  // A new expiry outranks a clear landing in the same cycle.
  always_comb begin
    ch_ce  = expire | clr_req;
    pend_d = expire | (pend_q & ~clr_req);
    irq_d  = (expire & enable) | (irq_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (ch_ce) begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pending = pend_q;
  assign irq     = irq_q;
endmodule

// File: rtl/tmr_irq_status_reg.sv
module tmr_irq_status_reg
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned REG_W  = DEF_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] irq
);
  localparam int unsigned PEND_LSB = pend_lsb(NUM_CH);
  localparam int unsigned USED_W   = used_width(NUM_CH);

  logic              rst_sync_n;
  logic [NUM_CH-1:0] enable;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] clr_req;
  logic              wr_rsvd_unused;

  tmr_irq_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr_irq_en_reg #(.NUM_CH(NUM_CH)) en_reg_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_en_bits (wr_data[NUM_CH-1:0]),
    .enable     (enable)
  );

  always_comb begin
    clr_req = wr_data[PEND_LSB +: NUM_CH] & {NUM_CH{wr_en}};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_irq_chan chan_i (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .expire  (expire[c]),
      .enable  (enable[c]),
      .clr_req (clr_req[c]),
      .pending (pending[c]),
      .irq     (irq[c])
    );
  end

  // Reserved write bits have no storage behind them.
  assign wr_rsvd_unused = ^wr_data[REG_W-1:USED_W];

  always_comb begin
    rd_data                       = '0;
    rd_data[NUM_CH-1:0]           = enable;
    rd_data[PEND_LSB +: NUM_CH]   = pending;
  end
endmodule

// File: rtl/tmr_irq_status_chk.sv
module tmr_irq_status_chk #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] expire,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic [NUM_CH-1:0] irq
);
  localparam int unsigned PL = NUM_CH;
  localparam int unsigned UW = 2 * NUM_CH;

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:UW] == '0);

  a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[NUM_CH-1:0] == $past(wr_data[NUM_CH-1:0]));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r2_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> rd_data[PL+i]);

    a_r3_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(expire[i] && rd_data[i]));

    a_r5_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[PL+i] && !expire[i]) |=> (!rd_data[PL+i] && !irq[i]));

    a_r6_no_rise_without_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[i] && !expire[i]) |=> !irq[i]);

    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !(wr_en && wr_data[PL+i])) |=> irq[i]);

    a_r8_irq_implies_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> rd_data[PL+i]);
  end
endmodule

bind tmr_irq_status_reg tmr_irq_status_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .expire  (expire),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq)
);

// File: tb/tmr_irq_status_reg_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_status_reg_tb_top;
  localparam int NCH = 5;

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  expire;
  logic            wr_en;
  logic [31:0]     wr_data;
  logic [31:0]     rd_data;
  logic [NCH-1:0]  irq;

  int checks;
  int failures;
  bit done;

  // Spec model state
  logic [NCH-1:0] m_en, m_pend, m_irq;

  // Scoreboard queues
  string          tag_q[$];
  logic [31:0]    rd_q[$];
  logic [NCH-1:0] irq_q[$];

  tmr_irq_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .expire(expire), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report(input string tag, input logic [31:0] a_rd,
                        input logic [31:0] e_rd, input logic [NCH-1:0] a_irq,
                        input logic [NCH-1:0] e_irq);
    checks++;
    if (a_rd !== e_rd || a_irq !== e_irq) begin
      failures++;
      $display("FAIL %s rd=%h exp=%h irq=%b exp=%b", tag, a_rd, e_rd, a_irq, e_irq);
    end
  endtask

  // Monitor: compare one expected item per cycle after the driver's edge.
  always @(negedge clk) begin
    if (tag_q.size() > 0) begin
      string t;
      logic [31:0] e_rd;
      logic [NCH-1:0] e_irq;
      t = tag_q.pop_front();
      e_rd = rd_q.pop_front();
      e_irq = irq_q.pop_front();
      report(t, rd_data, e_rd, irq, e_irq);
    end
  end

  // Driver: apply one cycle of stimulus, push the expected result.
  task automatic step(input string tag, input logic [NCH-1:0] ex,
                      input logic we, input logic [31:0] wd);
    logic [NCH-1:0] clr, n_en, n_pend, n_irq;
    @(negedge clk);
    expire  = ex;
    wr_en   = we;
    wr_data = wd;
    clr    = we ? wd[2*NCH-1:NCH] : '0;
    n_pend = ex | (m_pend & ~clr);
    n_irq  = (ex & m_en) | (m_irq & ~clr);
    n_en   = we ? wd[NCH-1:0] : m_en;
    @(posedge clk);
    #1;
    expire  = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    m_en = n_en; m_pend = n_pend; m_irq = n_irq;
    tag_q.push_back(tag);
    rd_q.push_back({22'b0, m_pend, m_en});
    irq_q.push_back(m_irq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    report("R1 during reset", rd_data, 32'h0, irq, '0);
    m_en = '0; m_pend = '0; m_irq = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; expire = '0; wr_en = 1'b0; wr_data = '0;
    m_en = '0; m_pend = '0; m_irq = '0;
    do_reset();
    step("R1 after reset idle", '0, 1'b0, 32'h0);
    step("R4 write enables 00101", '0, 1'b1, 32'h0000_0005);
    step("R2 R3 expire ch0 enabled ch1 disabled", 5'b00011, 1'b0, 32'h0);
    step("R2 hold idle", '0, 1'b0, 32'h0);
    step("R6 enable ch1 while pending", '0, 1'b1, 32'h0000_0007);
    step("R6 stays low later", '0, 1'b0, 32'h0);
    step("R7 clear all enables", '0, 1'b1, 32'h0000_0000);
    step("R7 line held", '0, 1'b0, 32'h0);
    step("R5 clear ch0 pending", '0, 1'b1, 32'h0000_0020);
    step("R5 zero leaves pending ch1", '0, 1'b1, 32'h0000_0000);
    step("R4 enable ch2", '0, 1'b1, 32'h0000_0004);
    step("R8 expiry wins over clear ch2", 5'b00100, 1'b1, 32'h0000_0084);
    step("R8 R3 old enable counts ch3", 5'b01000, 1'b1, 32'h0000_0108);
    step("R3 expire ch3 with enable now set", 5'b01000, 1'b0, 32'h0);
    step("R9 write all ones", '0, 1'b1, 32'hFFFF_FFFF);
    step("R2 R3 expire all enabled", 5'b11111, 1'b0, 32'h0);
    step("R9 upper bits only", '0, 1'b1, 32'hFFFF_FC1F);
    step("R5 clear ch4 and ch1", '0, 1'b1, 32'h0000_025F);
    step("R3 disabled expiry ch4", 5'b10000, 1'b1, 32'h0000_000F);
    step("R3 expire ch4 disabled", 5'b10000, 1'b0, 32'h0);
    step("R5 clear all", '0, 1'b1, 32'h0000_03E0);
    step("R4 enables 11010", '0, 1'b1, 32'h0000_001A);
    step("R2 R3 mixed expiry", 5'b01101, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    do_reset();
    step("R1 after second reset", '0, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule